// File: doc/BRIEF.md
# Four-Phase Interleaved Write Strobe Generator

This block turns one fast sample clock into a train of write strobes for a pair of analog storage banks, A and B. A two-bit divider rotates through four phase enables, so each phase is active on every fourth clock. Each phase advances its own token chain of `CHAIN_LEN` stages. The four chains together hold `4*CHAIN_LEN` strobes, and a single token walks through them. One new strobe rises on every input clock. Each strobe stays high for four clocks and so overlaps its three neighbours. The falling edge of a strobe is the sampling instant of its cell.

Strobes alternate between the two banks: A0, B0, A1, B1 and so on. Each bank therefore receives `2*CHAIN_LEN` strobes. A start request places the token at A0 on the next phase-0 step. After the last B strobe the token returns to A0 unless wrap is held off, in which case the sequence drains and the block goes idle. Each bank also gets two slow write clocks, each the OR of one half of that bank's strobes. An active-low master reset clears the divider, the chains and any pending start, and it acts asynchronously.

Top module: `strobe_gen`

## Requirements
- R1: While rst_n is low, every strobe and slow clock is 0, no start is pending, and phase_clk reads 4'b0001.
- R2: phase_clk is one-hot. It advances bit 0 to 1 to 2 to 3 and back to 0 on every clock, so each bit is high one clock in four.
- R3: A start seen at a clock edge while no strobe is high and none is pending is accepted. A0 then rises on the first later edge at which phase_clk[0] was high just before the edge.
- R4: The global strobe index k has strobe_a[i] at k=2i and strobe_b[i] at k=2i+1. At most one strobe rises per clock, and strobe k+1 (for k+1 < 4*CHAIN_LEN) rises exactly one clock after strobe k.
- R5: Every strobe stays high for exactly four clocks, so at most four are high together. Strobe k falls on the edge at which strobe k+4 rises.
- R6: If hold_wrap is low at the edge after strobe_b[2*CHAIN_LEN-1] rises, A0 rises at that edge.
- R7: If hold_wrap is high at that edge, no strobe rises, and all strobes are low four clocks later.
- R8: A start is ignored while any strobe is high or a start is pending.
- R9: slow_a[0] is the OR of strobe_a[CHAIN_LEN-1:0] and slow_a[1] is the OR of strobe_a[2*CHAIN_LEN-1:CHAIN_LEN]. The same rule holds for slow_b with strobe_b.
- R10: Strobe k rises only at an edge where phase_clk[k mod 4] was high just before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| start | input | 1 | Request to launch a token at A0 |
| hold_wrap | input | 1 | When high, stops the token from returning to A0 after the last strobe |
| phase_clk | output | 4 | One-hot rotating phase enables, each at quarter rate |
| strobe_a | output | 2*CHAIN_LEN | Bank A fast write strobes |
| strobe_b | output | 2*CHAIN_LEN | Bank B fast write strobes |
| slow_a | output | 2 | Bank A slow write clocks (ORs of strobe halves) |
| slow_b | output | 2 | Bank B slow write clocks (ORs of strobe halves) |

## Verification
Two functions can fall in the same cycle. The first case is the wrap from the last B strobe back to A0, which happens on the same edge where the hold_wrap decision is sampled and where strobe B15's three predecessors are still high. The second case is a start request that arrives while a token is running, or that arrives on the phase-0 edge itself. The bench launches starts at all four phase offsets, pulses start in mid-sequence, and toggles hold_wrap around the wrap edge. A behavioural reference model is compared with every output on every clock, and named checks measure the start latency, the A0 reappearance and the drain to idle.

// File: rtl/strobe_gen.sv
module strobe_gen #(
  parameter int CHAIN_LEN = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   hold_wrap,
  output logic [3:0]             phase_clk,
  output logic [2*CHAIN_LEN-1:0] strobe_a,
  output logic [2*CHAIN_LEN-1:0] strobe_b,
  output logic [1:0]             slow_a,
  output logic [1:0]             slow_b
);
  localparam int NSTB = 4 * CHAIN_LEN;

  logic [1:0]                  ph;
  logic                        armed;
  logic [3:0][CHAIN_LEN-1:0]   chain;
  logic [NSTB-1:0]             stb;
  logic                        idle;
  logic                        recirc;

  assign phase_clk = 4'b0001 << ph;
  assign idle      = ~|stb;
  assign recirc    = chain[3][CHAIN_LEN-1] & ~hold_wrap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph    <= 2'd0;
      armed <= 1'b0;
    end else begin
      ph    <= ph + 2'd1;
      armed <= (armed & (ph != 2'd0)) | (start & idle & ~armed);
    end

  for (genvar c = 0; c < 4; c++) begin : g_chain
    logic sin;
    if (c == 0) begin : g_head
      assign sin = armed | recirc;
    end else begin : g_link
      assign sin = chain[c-1][0];
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)               chain[c] <= '0;
      else if (ph == 2'(c))     chain[c] <= {chain[c][CHAIN_LEN-2:0], sin};

    for (genvar j = 0; j < CHAIN_LEN; j++) begin : g_tap
      assign stb[4*j+c] = chain[c][j];
    end
  end

  for (genvar i = 0; i < 2*CHAIN_LEN; i++) begin : g_bank
    assign strobe_a[i] = stb[2*i];
    assign strobe_b[i] = stb[2*i+1];
  end

  assign slow_a = {|strobe_a[2*CHAIN_LEN-1:CHAIN_LEN], |strobe_a[CHAIN_LEN-1:0]};
  assign slow_b = {|strobe_b[2*CHAIN_LEN-1:CHAIN_LEN], |strobe_b[CHAIN_LEN-1:0]};
endmodule

// File: rtl/strobe_gen_chk.sv
module strobe_gen_chk #(
  parameter int CHAIN_LEN = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [3:0]             phase_clk,
  input logic [2*CHAIN_LEN-1:0] strobe_a,
  input logic [2*CHAIN_LEN-1:0] strobe_b
);
  localparam int N = 4 * CHAIN_LEN;

  logic [N-1:0] stb, p1, p2, p3, p4, rise, pr;
  logic [3:0]   ph_q;

  for (genvar i = 0; i < 2*CHAIN_LEN; i++) begin : g_m
    assign stb[2*i]   = strobe_a[i];
    assign stb[2*i+1] = strobe_b[i];
  end

  assign rise = stb & ~p1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p1 <= '0; p2 <= '0; p3 <= '0; p4 <= '0; pr <= '0; ph_q <= 4'b0001;
    end else begin
      p1 <= stb; p2 <= p1; p3 <= p2; p4 <= p3; pr <= rise; ph_q <= phase_clk;
    end

  AST_PHASE_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase_clk == {$past(phase_clk[2:0]), $past(phase_clk[3])}); // R2

  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (|pr[N-2:0]) |-> (rise[N-1:1] == pr[N-2:0])); // R4

  AST_ONE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rise) <= 1); // R4

  AST_MAX_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stb) <= 4); // R5

  AST_SPAN_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((p1 & ~stb) & ~(p2 & p3 & p4)) == '0); // R5

  AST_SPAN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (stb & p1 & p2 & p3 & p4) == '0); // R5

  for (genvar k = 0; k < N; k++) begin : g_al
    AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      rise[k] |-> ph_q[k%4]); // R10
  end
endmodule

bind strobe_gen strobe_gen_chk #(.CHAIN_LEN(CHAIN_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .phase_clk(phase_clk),
  .strobe_a(strobe_a), .strobe_b(strobe_b)
);

// File: tb/strobe_gen_tb.sv
module strobe_gen_tb_top;
  localparam int  L    = 8;
  localparam int  N    = 4 * L;
  localparam time TCLK = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, hold_wrap = 1'b1;
  logic [3:0]     phase_clk;
  logic [2*L-1:0] strobe_a, strobe_b;
  logic [1:0]     slow_a, slow_b;

  int tests = 0, fails = 0, cyc = 0;
  int left[N];
  int last = -1;
  int ph = 0;
  bit arm = 1'b0;
  logic [N-1:0] prev_act = '0;
  logic [3:0]   prev_ph = 4'b0001;

  always #(TCLK/2) clk = ~clk;

  strobe_gen #(.CHAIN_LEN(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .hold_wrap(hold_wrap),
    .phase_clk(phase_clk), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .slow_a(slow_a), .slow_b(slow_b)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] act_vec();
    logic [N-1:0] v;
    for (int i = 0; i < 2*L; i++) begin
      v[2*i] = strobe_a[i];
      v[2*i+1] = strobe_b[i];
    end
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N; k++) left[k] = 0;
      last = -1; ph = 0; arm = 1'b0;
    end else begin
      bit idle_m, narm;
      int nxt;
      idle_m = 1'b1;
      for (int k = 0; k < N; k++) if (left[k] > 0) idle_m = 1'b0;
      nxt = -1;
      if (last >= 0) nxt = (last == N-1) ? (hold_wrap ? -1 : 0) : last + 1;
      if (arm && ph == 0) nxt = 0;
      narm = (arm && ph != 0) || (start && idle_m && !arm);
      for (int k = 0; k < N; k++) if (left[k] > 0) left[k]--;
      if (nxt >= 0) left[nxt] = 4;
      last = nxt;
      ph = (ph + 1) % 4;
      arm = narm;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (rst_n) begin
      logic [N-1:0] e, a, rises;
      logic [2*L-1:0] ea, eb;
      for (int k = 0; k < N; k++) e[k] = left[k] > 0;
      for (int i = 0; i < 2*L; i++) begin ea[i] = e[2*i]; eb[i] = e[2*i+1]; end
      a = act_vec();
      chk(phase_clk == (4'b0001 << ph), "R2 phase_clk", phase_clk, 4'b0001 << ph);
      chk(strobe_a == ea, "R4 R5 strobe_a", strobe_a, ea);
      chk(strobe_b == eb, "R4 R5 strobe_b", strobe_b, eb);
      chk(slow_a == {|ea[2*L-1:L], |ea[L-1:0]}, "R9 slow_a", slow_a, {|ea[2*L-1:L], |ea[L-1:0]});
      chk(slow_b == {|eb[2*L-1:L], |eb[L-1:0]}, "R9 slow_b", slow_b, {|eb[2*L-1:L], |eb[L-1:0]});
      rises = a & ~prev_act;
      if (rises != '0) begin
        chk($countones(rises) == 1, "R4 single rise", $countones(rises), 1);
        for (int k = 0; k < N; k++)
          if (rises[k]) chk(prev_ph[k%4], "R10 phase of rise", prev_ph, 4'b0001 << (k%4));
      end
      prev_act = a;
      prev_ph = phase_clk;
    end else begin
      prev_act = '0;
      prev_ph = 4'b0001;
    end
  end

  task automatic run_start(int p);
    int n;
    @(negedge clk);
    while (phase_clk != (4'b0001 << p)) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!strobe_a[0] && n < 20) begin @(negedge clk); n++; end
    chk(n == 2 + (3 - p), "R3 start latency", n, 2 + (3 - p));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(phase_clk == 4'b0001, "R1 reset phase", phase_clk, 1);
    chk({strobe_a, strobe_b, slow_a, slow_b} == '0, "R1 reset strobes",
        {strobe_a, strobe_b}, 0);
    #1 rst_n = 1'b1;

    for (int p = 0; p < 4; p++) begin
      hold_wrap = 1'b1;
      run_start(p);
      repeat (8) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      chk({strobe_a, strobe_b} == '0, "R7 R8 idle after drain", {strobe_a, strobe_b}, 0);
    end

    hold_wrap = 1'b0;
    run_start(2);
    begin
      int n = 0;
      while (!strobe_b[2*L-1] && n < 60) begin @(negedge clk); n++; end
    end
    @(negedge clk);
    chk(strobe_a[0] && strobe_b[2*L-1], "R6 wrap to A0", {strobe_a[0], strobe_b[2*L-1]}, 2'b11);
    repeat (30) @(negedge clk);
    hold_wrap = 1'b1;
    repeat (50) @(negedge clk);
    chk({strobe_a, strobe_b} == '0, "R7 drain after hold", {strobe_a, strobe_b}, 0);

    hold_wrap = 1'b0;
    run_start(1);
    repeat (10) @(negedge clk);
    #1 rst_n = 1'b0;
    #1;
    chk({strobe_a, strobe_b, slow_a, slow_b} == '0, "R1 async clear", {strobe_a, strobe_b}, 0);
    chk(phase_clk == 4'b0001, "R1 async phase", phase_clk, 1);
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk({strobe_a, strobe_b} == '0, "R1 no pending start after reset", {strobe_a, strobe_b}, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule